// File: doc/BRIEF.md
# Test-and-Test-and-Set Spin-Lock Agent

This block acquires and releases a shared lock word on behalf of one processor core. It keeps a private copy of the cache line that holds the lock. The core asks for the lock with a one-cycle acquire command and gives it back with a one-cycle release command.

While the private copy shows the lock taken, the agent waits on that copy alone and puts nothing on the coherence fabric. When its copy is missing, it asks the fabric for a shared copy. When the copy reads zero, it asks for exclusive ownership. That exclusive grant stands for an indivisible test-and-set: the fabric hands back the previous lock value and the lock word becomes 1. The agent wins when the previous value was zero. On a nonzero value it loses and goes back to waiting on its copy.

The fabric interface is reduced to a few signals. There are three level requests (shared read, exclusive test-and-set, store of zero), one grant pulse with a data word, and an invalidate pulse. An invalidate drops the private copy. If it arrives while an exclusive request is pending, it also cancels that request.

Top module: `tts_lock_agent`

## Requirements
- R1: Reset puts the agent in the idle state. It clears the private copy, drives every bus request low, and holds `acquired` and `holding` low.
- R2: An acquire command in idle with no valid private copy raises `busRdShared` on the next cycle. `busRdShared` stays high until a grant. The granted data word becomes the private copy.
- R3: While the private copy is valid and nonzero, the agent raises no bus request. Any nonzero value, not only 1, counts as taken.
- R4: A valid private copy equal to zero makes the agent raise `busRdExcl` on the following cycle. An acquire command in idle with a valid copy goes straight to this check, with no shared request.
- R5: An exclusive grant whose data word is zero makes `acquired` high for exactly the next cycle. `holding` rises on that same cycle.
- R6: An exclusive grant whose data word is nonzero returns the agent to silent spinning. `acquired` and `holding` stay low.
- R7: An invalidate while spinning, or while waiting for exclusive ownership without a grant, drops the private copy. `busRdShared` is high on the next cycle and `busRdExcl` is low.
- R8: A release command while holding lowers `holding` and raises `busWrZero` on the next cycle. `busWrZero` stays high until a grant. The agent then returns to idle with a valid private copy of zero.
- R9: The agent ignores an acquire command outside idle and a release command outside the held state. An invalidate while holding does not end `holding`.
- R10: At most one of `busRdShared`, `busRdExcl` and `busWrZero` is high in any cycle.
- R11: Three agents share one lock through a round-robin fabric. At most one of them holds the lock in any cycle, and every acquire command is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| acqReq | input | 1 | One-cycle acquire command from the core |
| relReq | input | 1 | One-cycle release command from the core |
| busGrant | input | 1 | One-cycle grant for the pending bus request |
| busInval | input | 1 | One-cycle invalidate of the private copy |
| busData | input | DATA_W | Lock word returned with a grant (previous value for test-and-set) |
| busRdShared | output | 1 | Request for a shared copy of the lock line |
| busRdExcl | output | 1 | Request for exclusive ownership with test-and-set |
| busWrZero | output | 1 | Request to store zero to the lock word |
| acquired | output | 1 | One-cycle pulse when the lock is won |
| holding | output | 1 | High while the lock is owned |

## Verification
Some rules are checked every cycle: the one-hot rule on bus requests, requests staying up until granted, and the one-cycle width of `acquired`. The outcome of each exclusive grant (win on zero, loss on nonzero) is checked every cycle as well. So is the rule that an invalidate cancels a pending exclusive request and turns it into a shared re-read, and the rule that holding persists until release. Other behaviour shows only in the bench's scenarios: a wide nonzero word counted as taken, the skipped shared read when a valid zero copy exists, and reset clearing the copy. Mutual exclusion among three contending agents, and the fact that every acquire finally completes, also depend on the bench's fabric model.

// File: rtl/tts_lock_pkg.sv
package tts_lock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPIN,
    ST_WAIT_SH,
    ST_WAIT_EX,
    ST_HELD,
    ST_REL
  } agentState_t;

  // strobes from control to the line-copy datapath
  typedef struct packed {
    logic fill;       // capture the granted data word
    logic drop;       // invalidate the private copy
    logic markSet;    // copy becomes 1 after a test-and-set
    logic markClear;  // copy becomes 0 after a release store
  } lineStrobe_t;

endpackage

// File: rtl/tts_lock_dp.sv
module tts_lock_dp
  import tts_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       strobe,
  input  logic [DATA_W-1:0] busData,
  output logic              lineValid,
  output logic              lineFree,
  output logic              respFree
);

  localparam logic [DATA_W-1:0] WORD_ZERO = '0;
  localparam logic [DATA_W-1:0] WORD_ONE  = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] lineWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= 1'b0;
      lineWord  <= WORD_ZERO;
    end else if (strobe.fill) begin
      lineValid <= 1'b1;
      lineWord  <= busData;
    end else if (strobe.markSet) begin
      lineValid <= 1'b1;
      lineWord  <= WORD_ONE;
    end else if (strobe.markClear) begin
      lineValid <= 1'b1;
      lineWord  <= WORD_ZERO;
    end else if (strobe.drop) begin
      lineValid <= 1'b0;
    end
  end

  assign lineFree = lineValid && (lineWord == WORD_ZERO);
  assign respFree = (busData == WORD_ZERO);

endmodule

// File: rtl/tts_lock_ctrl.sv
module tts_lock_ctrl
  import tts_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        acqReq,
  input  logic        relReq,
  input  logic        busGrant,
  input  logic        busInval,
  input  logic        lineValid,
  input  logic        lineFree,
  input  logic        respFree,
  output lineStrobe_t strobe,
  output logic        reqShared,
  output logic        reqExcl,
  output logic        reqWrZero,
  output logic        acquired,
  output logic        holding
);

  agentState_t state, nextState;
  logic winNow;

  always_comb begin
    nextState = state;
    strobe    = '0;
    winNow    = 1'b0;
    case (state)
      ST_IDLE: begin
        strobe.drop = busInval;
        if (acqReq) nextState = (lineValid && !busInval) ? ST_SPIN : ST_WAIT_SH;
      end
      ST_SPIN: begin
        if (busInval || !lineValid) begin
          strobe.drop = 1'b1;
          nextState   = ST_WAIT_SH;
        end else if (lineFree) begin
          nextState = ST_WAIT_EX;
        end
      end
      ST_WAIT_SH: begin
        if (busGrant) begin
          strobe.fill = 1'b1;
          nextState   = ST_SPIN;
        end
      end
      ST_WAIT_EX: begin
        if (busGrant) begin
          strobe.markSet = 1'b1;
          winNow         = respFree;
          nextState      = respFree ? ST_HELD : ST_SPIN;
        end else if (busInval) begin
          strobe.drop = 1'b1;
          nextState   = ST_WAIT_SH;
        end
      end
      ST_HELD: begin
        strobe.drop = busInval;
        if (relReq) nextState = ST_REL;
      end
      ST_REL: begin
        if (busGrant) begin
          strobe.markClear = 1'b1;
          nextState        = ST_IDLE;
        end else begin
          strobe.drop = busInval;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      acquired <= 1'b0;
    end else begin
      state    <= nextState;
      acquired <= winNow;
    end
  end

  assign reqShared = (state == ST_WAIT_SH);
  assign reqExcl   = (state == ST_WAIT_EX);
  assign reqWrZero = (state == ST_REL);
  assign holding   = (state == ST_HELD);

endmodule

// File: rtl/tts_lock_agent.sv
module tts_lock_agent
  import tts_lock_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acqReq,
  input  logic              relReq,
  input  logic              busGrant,
  input  logic              busInval,
  input  logic [DATA_W-1:0] busData,
  output logic              busRdShared,
  output logic              busRdExcl,
  output logic              busWrZero,
  output logic              acquired,
  output logic              holding
);

  lineStrobe_t strobe;
  logic lineValid, lineFree, respFree;

  tts_lock_ctrl ctrlI (
    .clk       (clk),
    .rstN      (rstN),
    .acqReq    (acqReq),
    .relReq    (relReq),
    .busGrant  (busGrant),
    .busInval  (busInval),
    .lineValid (lineValid),
    .lineFree  (lineFree),
    .respFree  (respFree),
    .strobe    (strobe),
    .reqShared (busRdShared),
    .reqExcl   (busRdExcl),
    .reqWrZero (busWrZero),
    .acquired  (acquired),
    .holding   (holding)
  );

  tts_lock_dp #(.DATA_W(DATA_W)) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busData   (busData),
    .lineValid (lineValid),
    .lineFree  (lineFree),
    .respFree  (respFree)
  );

endmodule

// File: rtl/tts_lock_agent_chk.sv
module tts_lock_agent_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              relReq,
  input logic              busGrant,
  input logic              busInval,
  input logic [DATA_W-1:0] busData,
  input logic              busRdShared,
  input logic              busRdExcl,
  input logic              busWrZero,
  input logic              acquired,
  input logic              holding
);

  a_r10_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busRdShared, busRdExcl, busWrZero}));

  a_r2_shared_held: assert property (@(posedge clk) disable iff (!rstN)
    busRdShared && !busGrant |=> busRdShared);

  a_r5_win: assert property (@(posedge clk) disable iff (!rstN)
    busRdExcl && busGrant && (busData == '0) |=> acquired && holding);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    acquired |=> !acquired);

  a_r6_lose: assert property (@(posedge clk) disable iff (!rstN)
    busRdExcl && busGrant && (busData != '0) |=> !acquired && !holding);

  a_r7_inval_cancel: assert property (@(posedge clk) disable iff (!rstN)
    busRdExcl && busInval && !busGrant |=> busRdShared && !busRdExcl);

  a_r8_release_done: assert property (@(posedge clk) disable iff (!rstN)
    busWrZero && busGrant |=> !busWrZero && !holding);

  a_r8_store_held: assert property (@(posedge clk) disable iff (!rstN)
    busWrZero && !busGrant |=> busWrZero);

  a_r9_hold_persist: assert property (@(posedge clk) disable iff (!rstN)
    holding && !relReq |=> holding);

  a_r3_quiet_held: assert property (@(posedge clk) disable iff (!rstN)
    holding |-> !busRdShared && !busRdExcl && !busWrZero);

endmodule

bind tts_lock_agent tts_lock_agent_chk #(.DATA_W(DATA_W)) chkI (
  .clk         (clk),
  .rstN        (rstN),
  .relReq      (relReq),
  .busGrant    (busGrant),
  .busInval    (busInval),
  .busData     (busData),
  .busRdShared (busRdShared),
  .busRdExcl   (busRdExcl),
  .busWrZero   (busWrZero),
  .acquired    (acquired),
  .holding     (holding)
);

// File: tb/tts_lock_agent_tb_top.sv
`timescale 1ns/1ps
module tts_lock_agent_tb_top;

  localparam int DW       = 32;
  localparam int N_AG     = 3;
  localparam int N_ROUNDS = 4;
  localparam int WDOG     = 50000;

  // {requirement number, {acq,rel,grant,inval,data0}, expected {sh,ex,wz,acquired,holding}}
  localparam int NV = 29;
  localparam logic [13:0] VEC [NV] = '{
    {4'd2, 5'b10000, 5'b10000},  // R2 acquire, no copy
    {4'd2, 5'b00000, 5'b10000},  // R2 request held
    {4'd3, 5'b00101, 5'b00000},  // R3 copy=1, silent
    {4'd3, 5'b00000, 5'b00000},  // R3 spin silent
    {4'd9, 5'b10000, 5'b00000},  // R9 acquire while spinning ignored
    {4'd7, 5'b00010, 5'b10000},  // R7 invalidate while spinning
    {4'd2, 5'b00100, 5'b00000},  // R2 fill zero copy
    {4'd4, 5'b00000, 5'b01000},  // R4 zero seen -> exclusive
    {4'd7, 5'b00010, 5'b10000},  // R7 invalidate cancels exclusive
    {4'd2, 5'b00100, 5'b00000},  // R2 refill zero
    {4'd4, 5'b00000, 5'b01000},  // R4 exclusive again
    {4'd6, 5'b00101, 5'b00000},  // R6 lost test-and-set
    {4'd6, 5'b00000, 5'b00000},  // R6 back to silent spin
    {4'd7, 5'b00010, 5'b10000},  // R7 release elsewhere invalidates
    {4'd2, 5'b00100, 5'b00000},  // R2 fill zero
    {4'd4, 5'b00000, 5'b01000},  // R4 exclusive
    {4'd5, 5'b00100, 5'b00011},  // R5 win: pulse and holding
    {4'd5, 5'b00000, 5'b00001},  // R5 pulse ends
    {4'd9, 5'b10000, 5'b00001},  // R9 acquire while holding ignored
    {4'd9, 5'b00010, 5'b00001},  // R9 invalidate keeps holding
    {4'd8, 5'b01000, 5'b00100},  // R8 release store
    {4'd8, 5'b00000, 5'b00100},  // R8 store held
    {4'd8, 5'b00100, 5'b00000},  // R8 back to idle
    {4'd9, 5'b01000, 5'b00000},  // R9 release in idle ignored
    {4'd4, 5'b10000, 5'b00000},  // R4 valid zero copy, no shared read
    {4'd4, 5'b00000, 5'b01000},  // R4 exclusive directly
    {4'd5, 5'b00100, 5'b00011},  // R5 win
    {4'd8, 5'b01000, 5'b00100},  // R8 release
    {4'd8, 5'b00100, 5'b00000}   // R8 idle
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;
  logic arbOn = 1'b0;

  // directed drive
  logic dAcq = 0, dRel = 0, dGnt = 0, dInv = 0;
  logic [DW-1:0] dData = '0;

  // fabric model outputs
  logic [N_AG-1:0] grantV, invV;
  logic [DW-1:0]   dataV;
  logic [N_AG-1:0] shV, exV, wzV, aqV, hdV;

  // agent 0 core drive
  logic acq0 = 0, rel0 = 0;

  logic oSh, oEx, oWz, oAq, oHd;
  logic inAcq, inRel, inGnt, inInv;
  logic [DW-1:0] inData;

  assign inAcq  = arbOn ? acq0 : dAcq;
  assign inRel  = arbOn ? rel0 : dRel;
  assign inGnt  = arbOn ? grantV[0] : dGnt;
  assign inInv  = arbOn ? invV[0] : dInv;
  assign inData = arbOn ? dataV : dData;

  tts_lock_agent #(.DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .acqReq(inAcq), .relReq(inRel),
    .busGrant(inGnt), .busInval(inInv), .busData(inData),
    .busRdShared(oSh), .busRdExcl(oEx), .busWrZero(oWz),
    .acquired(oAq), .holding(oHd)
  );

  assign shV[0] = oSh;
  assign exV[0] = oEx;
  assign wzV[0] = oWz;
  assign aqV[0] = oAq;
  assign hdV[0] = oHd;

  for (genvar g = 1; g < N_AG; g++) begin : g_peer
    logic pAcq = 0, pRel = 0;
    tts_lock_agent #(.DATA_W(DW)) peer_i (
      .clk(clk), .rstN(rstN), .acqReq(pAcq), .relReq(pRel),
      .busGrant(grantV[g]), .busInval(invV[g]), .busData(dataV),
      .busRdShared(shV[g]), .busRdExcl(exV[g]), .busWrZero(wzV[g]),
      .acquired(aqV[g]), .holding(hdV[g])
    );
    initial begin
      wait (arbOn);
      for (int n = 0; n < N_ROUNDS; n++) begin
        @(negedge clk); pAcq = 1;
        @(negedge clk); pAcq = 0;
        while (!hdV[g]) @(negedge clk);
        repeat (2 + g) @(negedge clk);
        pRel = 1;
        @(negedge clk); pRel = 0;
        while (hdV[g] || wzV[g]) @(negedge clk);
      end
    end
  end

  initial begin
    wait (arbOn);
    for (int n = 0; n < N_ROUNDS; n++) begin
      @(negedge clk); acq0 = 1;
      @(negedge clk); acq0 = 0;
      while (!oHd) @(negedge clk);
      repeat (2) @(negedge clk);
      rel0 = 1;
      @(negedge clk); rel0 = 0;
      while (oHd || oWz) @(negedge clk);
    end
  end

  // round-robin fabric model holding the lock word in memory
  logic [DW-1:0] memWord;
  int  rrPtr, pickIdx;
  logic pickValid, gap;

  always_comb begin
    pickValid = 1'b0;
    pickIdx   = 0;
    for (int k = 0; k < N_AG; k++) begin
      if (!pickValid && (shV[(rrPtr + k) % N_AG] || exV[(rrPtr + k) % N_AG] ||
                         wzV[(rrPtr + k) % N_AG])) begin
        pickValid = 1'b1;
        pickIdx   = (rrPtr + k) % N_AG;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantV  <= '0;
      invV    <= '0;
      dataV   <= '0;
      memWord <= '0;
      rrPtr   <= 0;
      gap     <= 1'b0;
    end else begin
      grantV <= '0;
      invV   <= '0;
      gap    <= 1'b0;
      if (arbOn && !gap && pickValid) begin
        gap              <= 1'b1;
        grantV[pickIdx]  <= 1'b1;
        dataV            <= memWord;
        rrPtr            <= (pickIdx + 1) % N_AG;
        if (exV[pickIdx]) begin
          memWord <= {{(DW-1){1'b0}}, 1'b1};
          invV    <= ~(N_AG'(1) << pickIdx);
        end else if (wzV[pickIdx]) begin
          memWord <= '0;
          invV    <= ~(N_AG'(1) << pickIdx);
        end
      end
    end
  end

  // contention monitors
  int overlapCnt = 0;
  int acqCnt [N_AG];
  initial for (int i = 0; i < N_AG; i++) acqCnt[i] = 0;

  always @(negedge clk) begin
    if (arbOn && rstN) begin
      if ($countones(hdV) > 1) overlapCnt = overlapCnt + 1;
      for (int i = 0; i < N_AG; i++) if (aqV[i]) acqCnt[i] = acqCnt[i] + 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {oSh, oEx, oWz, oAq, oHd};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 32'(outs()), 32'h0, "outputs during reset");
    rstN = 1;
    @(negedge clk);
    check("R1", 32'(outs()), 32'h0, "outputs after reset");

    // vector walk
    for (int v = 0; v < NV; v++) begin
      dAcq  = VEC[v][9];
      dRel  = VEC[v][8];
      dGnt  = VEC[v][7];
      dInv  = VEC[v][6];
      dData = {{(DW-1){1'b0}}, VEC[v][5]};
      @(negedge clk);
      check($sformatf("R%0d", VEC[v][13:10]), 32'(outs()), 32'(VEC[v][4:0]),
            $sformatf("vector %0d", v));
    end
    dAcq = 0; dRel = 0; dGnt = 0; dInv = 0; dData = '0;

    // R1: reset clears the valid zero copy left by the last release
    rstN = 0;
    @(negedge clk);
    check("R1", 32'(outs()), 32'h0, "outputs in mid-run reset");
    rstN = 1;
    dAcq = 1;
    @(negedge clk);
    dAcq = 0;
    check("R1", 32'(oSh), 32'h1, "copy cleared by reset, shared read needed");

    // R3: a wide nonzero word counts as taken
    dGnt = 1; dData = 32'h8000_0000;
    @(negedge clk);
    dGnt = 0; dData = '0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R3", 32'(outs()), 32'h0, "silent spin on high-bit value");
    end

    // R11: three-way contention through the fabric model
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    arbOn = 1;
    repeat (20) @(negedge clk);
    while (!((acqCnt[0] == N_ROUNDS) && (acqCnt[1] == N_ROUNDS) &&
             (acqCnt[2] == N_ROUNDS) && (hdV == '0) && (wzV == '0)))
      @(negedge clk);
    for (int i = 0; i < N_AG; i++)
      check("R11", 32'(acqCnt[i]), 32'(N_ROUNDS), $sformatf("acquisitions agent %0d", i));
    check("R11", 32'(overlapCnt), 32'h0, "cycles with more than one holder");
    check("R10", 32'($countones(shV | exV | wzV)), 32'h0, "requests quiet at end");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R11 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule